// File: doc/BRIEF.md
# Compare-Driven Output Pin Controller

This block owns one status bit that sets the level of an external output pin. When the timer counter reaches the value held in the compare register, a stored two-bit action code decides what happens to the bit: it is kept, cleared, set or inverted. Software can read the bit and write it directly. Software can also read and rewrite the action code.

The counter, the compare register and the bus decode are outside the block. The surrounding timer supplies the live counter value and the compare value. It also raises `cnt_tick` in the first cycle that a new counter value is presented, and it holds `cnt_en` high while the counter runs. An event fires only in a cycle where all three hold: the counter is enabled, the tick is present and the two values are equal. While the counter rests on the compare value between ticks, no further events fire.

There is no data stream through this block. Every pin is a plain control or status signal, and none uses a handshake or back-pressure. The software write strobes are single-cycle, and the block always accepts them.

Top module: `match_pin_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pin_out` and `bit_rd` read 0 and `act_rd` reads 2'b00.
- R2: An event with action code 2'b00 leaves the status bit unchanged.
- R3: An event with action code 2'b01 makes `pin_out` 0 from the next cycle on.
- R4: An event with action code 2'b10 makes `pin_out` 1 from the next cycle on.
- R5: An event with action code 2'b11 inverts `pin_out` on the next cycle.
- R6: An event fires only when `cnt_tick` is 1 and `cnt_val` equals `cmp_val`. Equality held over cycles without a tick changes nothing.
- R7: While `cnt_en` is 0, equality and ticks change nothing.
- R8: A pulse on `bit_wr` with no event loads `bit_wdata` into the status bit, visible on the next cycle.
- R9: When an event with a non-zero action code and a `bit_wr` pulse fall in the same cycle, the event's action decides the bit and the write is discarded. A toggle inverts the bit's value from before that cycle. With code 2'b00, the write takes effect.
- R10: A pulse on `act_wr` stores `act_wdata`, readable on `act_rd` from the next cycle. An event in the same cycle uses the code that was stored before the write.
- R11: `bit_rd` always equals `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter running |
| cnt_tick | input | 1 | First cycle of a new counter value |
| cnt_val | input | CNT_W | Live counter value |
| cmp_val | input | CNT_W | Compare register value |
| act_wr | input | 1 | Software write strobe for the action code |
| act_wdata | input | 2 | Action code to store |
| bit_wr | input | 1 | Software write strobe for the status bit |
| bit_wdata | input | 1 | Status bit value to store |
| act_rd | output | 2 | Stored action code |
| bit_rd | output | 1 | Status bit readback |
| pin_out | output | 1 | External match pin level |

## Verification
The bound checker checks on every cycle how each action code moves the pin after a qualified event. It also checks that the pin holds still when there is neither an event nor a write, that a lone write lands, that the action code register updates, and that the pin and the readback agree.

Some behaviours show only in the bench's scenarios, because they depend on what the stimulus does across several cycles. These are:
- that an equality held for several cycles acts only once;
- that a disabled counter masks events;
- the priority between a write and an event;
- the rule that an event uses the code stored before a same-cycle code write.

The bench drives these cases against its own cycle model.

// File: rtl/match_pin_pkg.sv
package match_pin_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_CLEAR  = 2'b01,
    ACT_SET    = 2'b10,
    ACT_INVERT = 2'b11
  } act_code_t;
endpackage

// File: rtl/match_hit_detect.sv
module match_hit_detect #(
  parameter int CNT_W = 16
) (
  input  logic             cnt_en,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit
);
  logic equal;
  // Qualify the compare so that a value resting between ticks fires once only.
  assign equal = (cnt_val == cmp_val);
  assign hit   = cnt_en & cnt_tick & equal;
endmodule

// File: rtl/match_act_store.sv
module match_act_store
  import match_pin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [1:0] wdata,
  output act_code_t code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code <= ACT_HOLD;
    else if (wr) code <= act_code_t'(wdata);
  end
endmodule

// File: rtl/match_bit_state.sv
module match_bit_state
  import match_pin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  act_code_t code,
  input  logic      wr,
  input  logic      wdata,
  output logic      state
);
  logic nxt;

  always_comb begin
    nxt = state;
    if (wr) nxt = wdata;
    // A compare event overrides a software write in the same cycle.
    if (hit) begin
      unique case (code)
        ACT_CLEAR:  nxt = 1'b0;
        ACT_SET:    nxt = 1'b1;
        ACT_INVERT: nxt = ~state;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= 1'b0;
    else        state <= nxt;
  end
endmodule

// File: rtl/match_pin_ctrl.sv
module match_pin_ctrl
  import match_pin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             act_wr,
  input  logic [1:0]       act_wdata,
  input  logic             bit_wr,
  input  logic             bit_wdata,
  output logic [1:0]       act_rd,
  output logic             bit_rd,
  output logic             pin_out
);
  logic      hit;
  act_code_t code;
  logic      state;

  match_hit_detect #(.CNT_W(CNT_W)) u_hit (
    .cnt_en   (cnt_en),
    .cnt_tick (cnt_tick),
    .cnt_val  (cnt_val),
    .cmp_val  (cmp_val),
    .hit      (hit)
  );

  match_act_store u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (act_wr),
    .wdata (act_wdata),
    .code  (code)
  );

  match_bit_state u_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .code  (code),
    .wr    (bit_wr),
    .wdata (bit_wdata),
    .state (state)
  );

  assign act_rd  = code;
  assign bit_rd  = state;
  assign pin_out = state;
endmodule

// File: rtl/match_pin_ctrl_chk.sv
module match_pin_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cmp_val,
  input logic             act_wr,
  input logic [1:0]       act_wdata,
  input logic             bit_wr,
  input logic             bit_wdata,
  input logic [1:0]       act_rd,
  input logic             bit_rd,
  input logic             pin_out
);
  logic ev;
  assign ev = cnt_en && cnt_tick && (cnt_val == cmp_val);

  // R3
  clear_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev && act_rd == 2'b01 |=> !pin_out);
  // R4
  set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev && act_rd == 2'b10 |=> pin_out);
  // R5
  invert_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev && act_rd == 2'b11 |=> pin_out != $past(pin_out));
  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev || act_rd == 2'b00) && !bit_wr |=> $stable(pin_out));
  // R8
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev && bit_wr |=> pin_out == $past(bit_wdata));
  // R10
  act_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_wr |=> act_rd == $past(act_wdata));
  // R11
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rd == pin_out);
endmodule

bind match_pin_ctrl match_pin_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_match_pin_ctrl.sv
`timescale 1ns/1ps
module sim_match_pin_ctrl;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, cnt_tick = 0, act_wr = 0, bit_wr = 0, bit_wdata = 0;
  logic [W-1:0] cnt_val = '0, cmp_val = '0;
  logic [1:0] act_wdata = '0, act_rd;
  logic bit_rd, pin_out;
  int vecs = 0, errs = 0;
  int exp_pin = 0, exp_act = 0;

  always #5 clk = ~clk;

  match_pin_ctrl #(.CNT_W(W)) u0 (.*);

  task automatic cmp(input string tag);
    vecs++;
    if (pin_out !== exp_pin[0] || bit_rd !== exp_pin[0] || act_rd !== exp_act[1:0]) begin
      errs++;
      $display("FAIL %s: pin=%0b rd=%0b act=%0d expected pin=%0d act=%0d",
               tag, pin_out, bit_rd, act_rd, exp_pin, exp_act);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare after the edge.
  task automatic step(input logic en, input logic tk, input int cv, input int mv,
                      input logic aw, input int ad, input logic bw, input logic bd,
                      input string tag);
    int np;
    bit ev;
    cnt_en = en; cnt_tick = tk; cnt_val = cv[W-1:0]; cmp_val = mv[W-1:0];
    act_wr = aw; act_wdata = ad[1:0]; bit_wr = bw; bit_wdata = bd;
    ev = en && tk && (cv == mv);
    np = exp_pin;
    if (bw) np = bd;
    if (ev) begin
      if (exp_act == 1) np = 0;
      else if (exp_act == 2) np = 1;
      else if (exp_act == 3) np = 1 - exp_pin;
    end
    @(posedge clk);
    exp_pin = np;
    if (aw) exp_act = ad;
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release");
    // R2: code 00 event leaves the bit alone
    step(1,0,0,5,0,0,1,1,"R8 write one");
    step(1,1,5,5,0,0,0,0,"R2 hold code");
    // R3
    step(1,0,5,5,1,1,0,0,"R10 store clear");
    step(1,1,5,5,0,0,0,0,"R3 clear");
    // R4, R6: equality held without tick does nothing
    step(1,0,5,5,1,2,0,0,"R10 store set");
    step(1,0,5,5,0,0,0,0,"R6 no tick");
    step(1,1,4,5,0,0,0,0,"R6 unequal");
    step(1,1,5,5,0,0,0,0,"R4 set");
    // R5 toggle twice and held equality
    step(1,0,5,5,1,3,0,0,"R10 store invert");
    step(1,1,5,5,0,0,0,0,"R5 invert");
    step(1,0,5,5,0,0,0,0,"R6 held equal");
    step(1,1,9,9,0,0,0,0,"R5 invert again");
    // R7
    step(0,1,9,9,0,0,0,0,"R7 disabled");
    step(0,1,9,9,0,0,1,0,"R8 write zero");
    step(0,1,9,9,0,0,0,0,"R7 disabled again");
    // R9 conflicts
    step(1,1,7,7,0,0,1,0,"R9 invert beats write");
    step(1,0,7,7,1,1,0,0,"R10 store clear");
    step(1,1,7,7,0,0,1,1,"R9 clear beats write");
    step(1,0,7,7,1,0,0,0,"R10 store hold");
    step(1,1,7,7,0,0,1,1,"R9 write with hold code");
    // R10: same-cycle code write uses old code
    step(1,1,3,3,1,1,0,0,"R10 old code used");
    step(1,1,3,3,1,2,0,0,"R10 clear applied");
    step(1,1,3,3,0,0,0,0,"R4 set after rewrite");
    step(1,1,65535,65535,1,3,0,0,"R11 top value");
    step(1,1,65535,65535,0,0,0,0,"R5 at top value");
    // R1 reset mid-run
    rst_n = 1'b0;
    exp_pin = 0; exp_act = 0;
    @(negedge clk);
    cmp("R1 reset mid-run");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule